// File: doc/BRIEF.md
# Paged and Indexed Memory Address Generator

This block forms the 12-bit word address for a CPU whose memory holds 4096 words of 12 bits, seen as 32 pages of 128 words. Every cycle a four-bit source enable picks where the address comes from. The first source is the program counter. The second is one of a bank of general registers used as an indirect pointer. The third is a paged direct address, made from the current page number and the low seven bits of the instruction word. The fourth is the index register plus an unsigned five-bit displacement taken from the instruction. The chosen address is registered and appears one clock after the request, with a valid strobe.

The block also holds the selection register. This register carries a 4-bit channel number and a 5-bit current page. It can be loaded as a whole word. Its channel field can be loaded alone from the write data. Its page field can be loaded alone from the instruction word, which is how a page-switch instruction moves the program to another page. When more than one source is enabled at once, a fixed priority picks the winner and a registered conflict flag is raised.

Top module: `paged_addr_gen`

## Requirements
- R1: With src_en bit 0 (program counter) enabled, addr_q equals pc_val one clock later.
- R2: With src_en bit 1 (pointer) enabled, addr_q equals the ptr_bank slice selected by ptr_sel one clock later. Slice k is bits 12k+11 down to 12k.
- R3: With src_en bit 2 (direct) enabled, addr_q bits 11-7 equal the current page field and bits 6-0 equal ir bits 6-0, one clock later.
- R4: With src_en bit 3 (indexed) enabled, addr_q equals (ix_val + ir bits 4-0) modulo 4096, with the displacement taken as unsigned, one clock later.
- R5: When several enables are set, the lowest-numbered set bit wins. src_conflict is 1 in the same cycle the address appears, and is 0 after any cycle with at most one enable.
- R6: After a cycle with src_en all zero, addr_vld is 0, src_conflict is 0 and addr_q keeps its previous value. After any enabled cycle, addr_vld is 1.
- R7: sel_q bits 3-0 hold the channel, bits 8-4 hold the page, and bits 11-9 always read 0. A word write (sel_wr_word) loads bits 8-0 of sel_wdata and ignores bits 11-9.
- R8: sel_wr_chan loads the channel from sel_wdata bits 3-0 and leaves the page unchanged. sel_wr_page loads the page from ir bits 4-0 and leaves the channel unchanged. Both together load both fields.
- R9: When sel_wr_word is set, it takes precedence over sel_wr_chan and sel_wr_page.
- R10: A direct access in the same cycle as a page write uses the old page. The new page applies from the next cycle.
- R11: After reset, addr_q, addr_vld, src_conflict and sel_q are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en | input | 4 | Source enables: bit0 program counter, bit1 pointer, bit2 direct, bit3 indexed |
| pc_val | input | 12 | Program counter value |
| ptr_bank | input | 48 | Flattened bank of pointer-capable registers, 12 bits each |
| ptr_sel | input | 2 | Selects the pointer register |
| ix_val | input | 12 | Index register value |
| ir | input | 12 | Instruction word (offset, displacement, new page) |
| sel_wdata | input | 12 | Write data for the selection register |
| sel_wr_word | input | 1 | Load the whole selection register |
| sel_wr_chan | input | 1 | Load only the channel field |
| sel_wr_page | input | 1 | Load only the page field, taken from the instruction |
| addr_q | output | 12 | Registered memory address |
| addr_vld | output | 1 | Address was produced in the last cycle |
| src_conflict | output | 1 | More than one source was enabled in the last cycle |
| sel_q | output | 12 | Selection register read value |

## Verification
Each mode is tried alone first. The program counter is walked across values. Every pointer slot is read with distinct contents, which shows whether the slice index is wrong. Direct mode is run on pages 0, 31 and a middle page with offsets at both ends, which separates the page bits from the offset bits. Indexed mode is run at zero displacement, at full displacement, and across the 4095/0 wrap, which exposes a sign-extended or truncated sum. After that, pairs and triples of enables probe the priority order and the conflict flag. Field writes, word writes with the top bits set, and page writes in the same cycle as direct accesses show field isolation and ordering. Long runs of random vectors mix all of these.

// File: rtl/paged_addr_gen.sv
module paged_addr_gen #(
  parameter int AW     = 12,
  parameter int PAGE_W = 5,
  parameter int CHAN_W = 4,
  parameter int DISP_W = 5,
  parameter int NPTR   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [3:0]              src_en,
  input  logic [AW-1:0]           pc_val,
  input  logic [NPTR*AW-1:0]      ptr_bank,
  input  logic [$clog2(NPTR)-1:0] ptr_sel,
  input  logic [AW-1:0]           ix_val,
  input  logic [AW-1:0]           ir,
  input  logic [AW-1:0]           sel_wdata,
  input  logic                    sel_wr_word,
  input  logic                    sel_wr_chan,
  input  logic                    sel_wr_page,
  output logic [AW-1:0]           addr_q,
  output logic                    addr_vld,
  output logic                    src_conflict,
  output logic [AW-1:0]           sel_q
);

  localparam int OFF_W   = AW - PAGE_W;
  localparam int SEL_TOP = CHAN_W + PAGE_W;

  logic [CHAN_W-1:0] chan_q;
  logic [PAGE_W-1:0] page_q;
  logic [AW-1:0]     ptr_arr [NPTR];
  logic [AW-1:0]     ptr_pick, dir_addr, idx_addr, addr_nx;
  logic              multi;

  for (genvar k = 0; k < NPTR; k++) begin : g_ptr
    assign ptr_arr[k] = ptr_bank[k*AW +: AW];
  end

  assign ptr_pick = ptr_arr[ptr_sel];
  assign dir_addr = {page_q, ir[OFF_W-1:0]};
  assign idx_addr = ix_val + {{(AW-DISP_W){1'b0}}, ir[DISP_W-1:0]};
  assign multi    = (src_en & (src_en - 4'd1)) != 4'd0;

  always_comb begin
    if      (src_en[0]) addr_nx = pc_val;
    else if (src_en[1]) addr_nx = ptr_pick;
    else if (src_en[2]) addr_nx = dir_addr;
    else if (src_en[3]) addr_nx = idx_addr;
    else                addr_nx = addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q       <= '0;
      addr_vld     <= 1'b0;
      src_conflict <= 1'b0;
    end else begin
      addr_q       <= addr_nx;
      addr_vld     <= |src_en;
      src_conflict <= multi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      page_q <= '0;
    end else if (sel_wr_word) begin
      chan_q <= sel_wdata[CHAN_W-1:0];
      page_q <= sel_wdata[SEL_TOP-1:CHAN_W];
    end else begin
      if (sel_wr_chan) chan_q <= sel_wdata[CHAN_W-1:0];
      if (sel_wr_page) page_q <= ir[PAGE_W-1:0];
    end
  end

  assign sel_q = {{(AW-SEL_TOP){1'b0}}, page_q, chan_q};

  AST_PC_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    src_en[0] |=> addr_q == $past(pc_val)); // R1
  AST_DIRECT_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    src_en == 4'b0100 |=> addr_q == {$past(sel_q[SEL_TOP-1:CHAN_W]), $past(ir[OFF_W-1:0])}); // R3
  AST_CONFLICT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(src_en) > 1 |=> src_conflict); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    src_en == 4'b0000 |=> $stable(addr_q) && !addr_vld); // R6
  AST_SEL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q[AW-1:SEL_TOP] == '0); // R7
  AST_CHAN_KEEPS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr_chan && !sel_wr_word && !sel_wr_page |=> $stable(sel_q[SEL_TOP-1:CHAN_W])); // R8
  AST_PAGE_KEEPS_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr_page && !sel_wr_word && !sel_wr_chan |=> $stable(sel_q[CHAN_W-1:0])); // R8

endmodule

// File: tb/tb_paged_addr_gen.sv
module tb_paged_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_en = '0;
  logic [11:0] pc_val = '0;
  logic [47:0] ptr_bank = '0;
  logic [1:0]  ptr_sel = '0;
  logic [11:0] ix_val = '0;
  logic [11:0] ir = '0;
  logic [11:0] sel_wdata = '0;
  logic        sel_wr_word = 1'b0, sel_wr_chan = 1'b0, sel_wr_page = 1'b0;
  logic [11:0] addr_q, sel_q;
  logic        addr_vld, src_conflict;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  int m_addr, m_vld, m_err, m_chan, m_page;

  paged_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .pc_val(pc_val),
    .ptr_bank(ptr_bank), .ptr_sel(ptr_sel), .ix_val(ix_val), .ir(ir),
    .sel_wdata(sel_wdata), .sel_wr_word(sel_wr_word), .sel_wr_chan(sel_wr_chan),
    .sel_wr_page(sel_wr_page), .addr_q(addr_q), .addr_vld(addr_vld),
    .src_conflict(src_conflict), .sel_q(sel_q)
  );

  always #5 clk = ~clk;

  // Behavioural reference: integers, evaluated on each rising edge
  always @(posedge clk) begin
    int n;
    if (!rst_n) begin
      m_addr = 0; m_vld = 0; m_err = 0; m_chan = 0; m_page = 0;
    end else begin
      n = 0;
      for (int b = 0; b < 4; b++) if (src_en[b]) n++;
      m_err = (n > 1);
      m_vld = (n > 0);
      if (src_en[0])      m_addr = int'(pc_val);
      else if (src_en[1]) m_addr = int'((ptr_bank >> (int'(ptr_sel) * 12)) & 48'hFFF);
      else if (src_en[2]) m_addr = m_page * 128 + int'(ir) % 128;
      else if (src_en[3]) m_addr = (int'(ix_val) + int'(ir) % 32) % 4096;
      if (sel_wr_word) begin
        m_chan = int'(sel_wdata) % 16;
        m_page = (int'(sel_wdata) / 16) % 32;
      end else begin
        if (sel_wr_chan) m_chan = int'(sel_wdata) % 16;
        if (sel_wr_page) m_page = int'(ir) % 32;
      end
    end
  end

  task automatic tick(input string tag);
    @(negedge clk);
    vectors++;
    if (int'(addr_q) != m_addr || int'(addr_vld) != m_vld ||
        int'(src_conflict) != m_err || int'(sel_q) != m_page * 16 + m_chan) begin
      miscompares++;
      $display("FAIL %s: addr=%0d vld=%0d conf=%0d sel=%0d expected addr=%0d vld=%0d conf=%0d sel=%0d",
               tag, addr_q, addr_vld, src_conflict, sel_q, m_addr, m_vld, m_err, m_page * 16 + m_chan);
    end
  endtask

  task automatic quiet();
    src_en = '0; sel_wr_word = 0; sel_wr_chan = 0; sel_wr_page = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    miscompares++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    ptr_bank = {12'hC3A, 12'h5F0, 12'h0FF, 12'hA11};
    repeat (3) tick("R11 reset");
    rst_n = 1'b1;
    tick("R11 after reset");

    // R1 program counter walk
    for (int v = 0; v < 4096; v += 819) begin
      src_en = 4'b0001; pc_val = 12'(v); tick("R1 pc");
    end
    pc_val = 12'hFFF; tick("R1 pc max");

    // R2 each pointer slot
    for (int s = 0; s < 4; s++) begin
      src_en = 4'b0010; ptr_sel = 2'(s); tick("R2 pointer");
    end

    // R8 page-only write, then R3 direct on pages 31, 0, 13
    quiet(); sel_wr_page = 1; ir = 12'hFFF; tick("R8 page write");
    quiet(); src_en = 4'b0100; ir = 12'h07F; tick("R3 direct page31");
    ir = 12'h000; tick("R3 direct off0");
    quiet(); sel_wr_page = 1; ir = 12'h000; tick("R8 page zero");
    quiet(); src_en = 4'b0100; ir = 12'hF80; tick("R3 direct page0");
    // R10 direct in same cycle as page write uses old page
    quiet(); src_en = 4'b0100; sel_wr_page = 1; ir = 12'h00D; tick("R10 same-cycle");
    quiet(); src_en = 4'b0100; ir = 12'h055; tick("R10 next cycle");

    // R4 indexed: zero disp, full disp, wrap
    quiet(); src_en = 4'b1000; ix_val = 12'h123; ir = 12'hFE0; tick("R4 disp0");
    ir = 12'h01F; tick("R4 disp31");
    ix_val = 12'hFFA; ir = 12'h01F; tick("R4 wrap");
    ix_val = 12'hFFF; ir = 12'h001; tick("R4 wrap to 0");

    // R5 priority and conflict
    pc_val = 12'h321; ptr_sel = 2'd2; ix_val = 12'h010; ir = 12'h005;
    src_en = 4'b1111; tick("R5 all");
    src_en = 4'b1110; tick("R5 ptr wins");
    src_en = 4'b1100; tick("R5 direct wins");
    src_en = 4'b1001; tick("R5 pc over idx");
    src_en = 4'b1000; tick("R5 single clears");

    // R6 idle hold
    quiet(); tick("R6 idle"); tick("R6 idle2");
    src_en = 4'b0001; pc_val = 12'h777; tick("R6 resume");

    // R7 word write ignores top bits
    quiet(); sel_wr_word = 1; sel_wdata = 12'hFFF; tick("R7 word ones");
    quiet(); sel_wr_word = 1; sel_wdata = 12'hE5A; tick("R7 word mixed");
    // R8 channel only, both
    quiet(); sel_wr_chan = 1; sel_wdata = 12'hFF3; tick("R8 chan only");
    quiet(); sel_wr_chan = 1; sel_wr_page = 1; sel_wdata = 12'h00C; ir = 12'h011; tick("R8 both");
    // R9 word precedence
    quiet(); sel_wr_word = 1; sel_wr_chan = 1; sel_wr_page = 1;
    sel_wdata = 12'h0A5; ir = 12'h01E; tick("R9 word wins");
    quiet(); tick("R9 settle");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      src_en = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) == 0) src_en = 4'b0100;
      pc_val = 12'($urandom); ix_val = 12'($urandom); ir = 12'($urandom);
      ptr_sel = 2'($urandom); ptr_bank = {16'($urandom), 32'($urandom)};
      sel_wdata = 12'($urandom);
      sel_wr_word = ($urandom_range(0, 7) == 0);
      sel_wr_chan = ($urandom_range(0, 3) == 0);
      sel_wr_page = ($urandom_range(0, 3) == 0);
      tick("R1-mix random");
    end

    // Reset in the middle
    quiet(); rst_n = 1'b0; tick("R11 reassert");
    rst_n = 1'b1; tick("R11 released");
    finish_run();
  end
endmodule